// File: doc/BRIEF.md
# Threshold Comparator with Auto-Retrigger

This block sits behind the computation stage of a sampling converter. Each time that stage reports a finished result, the block forms a signed 16-bit error from it. The error is one of three things, chosen by configuration: the result minus the previously captured result, the result minus a setpoint, or the filtered value minus a setpoint. The block keeps that error in an output register. It then tests the error against a programmable lower and upper threshold under a selectable interrupt condition, and sets a sticky interrupt flag when the condition holds.

The block also owns the conversion-go bit that starts the converter. The bit is set by a software start pulse or by a rising edge on one selected trigger input. That input passes through a two-flop synchronizer and then an edge detector. In single mode the bit drops after each threshold test. In continuous mode it stays set, so a new conversion follows each test at once. It stops only when the interrupt condition is met while stop-on-interrupt is enabled.

A three-state sequencer runs the block:
- IDLE: go is low; a start request moves to BUSY.
- BUSY: go is high and the block waits for the completion strobe; the strobe captures the error and moves to EVAL.
- EVAL: one cycle of threshold test. It returns to BUSY when continuous mode keeps running, and otherwise goes to IDLE.

Top module: `cmp_retrig`

## Requirements
- R1: After reset, go is low, the error register is zero and the interrupt flag is clear.
- R2: A sw_start pulse while go is low raises go on the next clock edge. A rising edge on trig_in[cfg_trig_sel] raises go on the third clock edge after the input changes. Edges on unselected trigger inputs have no effect.
- R3: Trigger edges and start pulses that arrive while go is high are dropped, not remembered. go falls after the test and stays low.
- R4: When done is sampled high while go is high and no test is in progress, err_out is updated on that edge. The value is computed with 16-bit wraparound subtraction, selected by cfg_calc_sel: 00 gives result minus the previous captured result (zero after reset); 01 and 11 give result minus setpoint; 10 gives filtered minus setpoint. The previous-result register follows every captured result, whatever the mode.
- R5: The interrupt condition is selected by cfg_irq_mode, with a signed comparison of err against lower and upper: 0 never; 1 err < lower; 2 err >= lower; 3 lower <= err < upper; 4 err < lower or err >= upper; 5 err < upper; 6 err >= upper; 7 always.
- R6: The test takes place one cycle after capture. irq_flag is set on the following edge if the condition holds. It then stays set until an irq_clr pulse, and a new set wins over a clear in the same cycle.
- R7: With cfg_cont low, go falls on the edge that ends the test cycle, two edges after done is sampled.
- R8: With cfg_cont high, go stays high after the test. The only exception is a test whose condition holds while cfg_stop_on_irq is high; then go falls as in R7.
- R9: A done strobe while go is low changes neither err_out nor irq_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_calc_sel | input | 2 | Error calculation select |
| cfg_irq_mode | input | 3 | Interrupt condition select |
| cfg_cont | input | 1 | Continuous retrigger enable |
| cfg_stop_on_irq | input | 1 | Stop continuous run when condition holds |
| cfg_trig_sel | input | 2 | Index of the active trigger input |
| trig_in | input | 4 | Asynchronous trigger sources |
| sw_start | input | 1 | Software start pulse |
| result | input | 16 | Post-processed value from computation stage |
| filtered | input | 16 | Filtered value from computation stage |
| setpoint | input | 16 | Setpoint for error calculation |
| upper_th | input | 16 | Signed upper threshold |
| lower_th | input | 16 | Signed lower threshold |
| done | input | 1 | Completion strobe from computation stage |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| go | output | 1 | Conversion-go bit |
| err_out | output | 16 | Captured signed error |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest case is a trigger edge that arrives while a conversion is already running. It should leave no trace, and the only evidence is the absence of a later retrigger. To reach it, the bench raises the selected trigger to start a conversion, lowers it, and raises it again while go is still high. It then completes the conversion in single mode and watches go stay low for several cycles. A second hard case is continuous mode stopping on exactly the test whose condition holds. The bench reaches it by switching the interrupt condition from never to always between two completion strobes of one continuous run.

// File: rtl/cmp_retrig_pkg.sv
package cmp_retrig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_EVAL = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        CALC_DELTA    = 2'd0,
        CALC_SETPT    = 2'd1,
        CALC_FILT     = 2'd2,
        CALC_RESERVED = 2'd3
    } calc_sel_t;

    typedef enum logic [2:0] {
        IRQ_NEVER     = 3'd0,
        IRQ_LT_LOW    = 3'd1,
        IRQ_GE_LOW    = 3'd2,
        IRQ_INSIDE    = 3'd3,
        IRQ_OUTSIDE   = 3'd4,
        IRQ_LT_UP     = 3'd5,
        IRQ_GE_UP     = 3'd6,
        IRQ_ALWAYS    = 3'd7
    } irq_mode_t;

endpackage

// File: rtl/cmp_trig_sync.sv
module cmp_trig_sync #(
    parameter int NTRIG       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int TSW        = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [TSW-1:0]   trig_sel,
    output logic             trig_edge
);

    logic [SYNC_STAGES-1:0][NTRIG-1:0] stage_q;
    logic                              sel_now;
    logic                              sel_prev_q;

    // Synchronizer chain, one column per trigger input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= trig_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sel_now = stage_q[SYNC_STAGES-1][trig_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev_q <= 1'b0;
        end else begin
            sel_prev_q <= sel_now;
        end
    end

    assign trig_edge = sel_now & ~sel_prev_q;

endmodule

// File: rtl/cmp_err_calc.sv
module cmp_err_calc
    import cmp_retrig_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [1:0]    calc_sel,
    input  logic [DW-1:0] result,
    input  logic [DW-1:0] filtered,
    input  logic [DW-1:0] setpoint,
    output logic [DW-1:0] err_q
);

    logic [DW-1:0] prev_q;
    logic [DW-1:0] minuend;
    logic [DW-1:0] subtrahend;

    always_comb begin
        unique case (calc_sel_t'(calc_sel))
            CALC_DELTA: begin
                minuend    = result;
                subtrahend = prev_q;
            end
            CALC_FILT: begin
                minuend    = filtered;
                subtrahend = setpoint;
            end
            CALC_SETPT, CALC_RESERVED: begin
                minuend    = result;
                subtrahend = setpoint;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= '0;
            prev_q <= '0;
        end else if (capture) begin
            err_q  <= minuend - subtrahend;
            prev_q <= result;
        end
    end

endmodule

// File: rtl/cmp_thresh.sv
module cmp_thresh
    import cmp_retrig_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] err,
    input  logic [DW-1:0] upper_th,
    input  logic [DW-1:0] lower_th,
    input  logic [2:0]    irq_mode,
    output logic          hit
);

    logic lt_low;
    logic lt_up;

    assign lt_low = $signed(err) < $signed(lower_th);
    assign lt_up  = $signed(err) < $signed(upper_th);

    always_comb begin
        unique case (irq_mode_t'(irq_mode))
            IRQ_NEVER:   hit = 1'b0;
            IRQ_LT_LOW:  hit = lt_low;
            IRQ_GE_LOW:  hit = ~lt_low;
            IRQ_INSIDE:  hit = ~lt_low & lt_up;
            IRQ_OUTSIDE: hit = lt_low | ~lt_up;
            IRQ_LT_UP:   hit = lt_up;
            IRQ_GE_UP:   hit = ~lt_up;
            IRQ_ALWAYS:  hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmp_seq_ctrl.sv
module cmp_seq_ctrl
    import cmp_retrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic done,
    input  logic hit,
    input  logic cont,
    input  logic stop_on_irq,
    input  logic irq_clr,
    output logic go,
    output logic capture,
    output logic st_eval,
    output logic irq_flag
);

    seq_state_t state_q;
    seq_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_BUSY;
            ST_BUSY: if (done)      state_d = ST_EVAL;
            ST_EVAL: begin
                if (cont && !(hit && stop_on_irq)) state_d = ST_BUSY;
                else                               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        go      = 1'b0;
        capture = 1'b0;
        st_eval = 1'b0;
        unique case (state_q)
            ST_IDLE: go = 1'b0;
            ST_BUSY: begin
                go      = 1'b1;
                capture = done;
            end
            ST_EVAL: begin
                go      = 1'b1;
                st_eval = 1'b1;
            end
            default: go = 1'b0;
        endcase
    end

    // Sticky interrupt flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (st_eval && hit) begin
            irq_flag <= 1'b1;
        end else if (irq_clr) begin
            irq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cmp_retrig.sv
module cmp_retrig
    import cmp_retrig_pkg::*;
#(
    parameter int DW          = 16,
    parameter int NTRIG       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int TSW        = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_calc_sel,
    input  logic [2:0]       cfg_irq_mode,
    input  logic             cfg_cont,
    input  logic             cfg_stop_on_irq,
    input  logic [TSW-1:0]   cfg_trig_sel,
    input  logic [NTRIG-1:0] trig_in,
    input  logic             sw_start,
    input  logic [DW-1:0]    result,
    input  logic [DW-1:0]    filtered,
    input  logic [DW-1:0]    setpoint,
    input  logic [DW-1:0]    upper_th,
    input  logic [DW-1:0]    lower_th,
    input  logic             done,
    input  logic             irq_clr,
    output logic             go,
    output logic [DW-1:0]    err_out,
    output logic             irq_flag
);

    logic trig_edge;
    logic start_req;
    logic capture;
    logic st_eval;
    logic hit;

    cmp_trig_sync #(
        .NTRIG       (NTRIG),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_sel  (cfg_trig_sel),
        .trig_edge (trig_edge)
    );

    assign start_req = sw_start | trig_edge;

    cmp_err_calc #(.DW(DW)) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .calc_sel (cfg_calc_sel),
        .result   (result),
        .filtered (filtered),
        .setpoint (setpoint),
        .err_q    (err_out)
    );

    cmp_thresh #(.DW(DW)) u_cmp (
        .err      (err_out),
        .upper_th (upper_th),
        .lower_th (lower_th),
        .irq_mode (cfg_irq_mode),
        .hit      (hit)
    );

    cmp_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .done        (done),
        .hit         (hit),
        .cont        (cfg_cont),
        .stop_on_irq (cfg_stop_on_irq),
        .irq_clr     (irq_clr),
        .go          (go),
        .capture     (capture),
        .st_eval     (st_eval),
        .irq_flag    (irq_flag)
    );

endmodule

// File: rtl/cmp_retrig_chk.sv
module cmp_retrig_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic          done,
    input logic          sw_start,
    input logic          trig_edge,
    input logic          st_eval,
    input logic          hit,
    input logic          cont,
    input logic          stop_on_irq,
    input logic          irq_clr,
    input logic          irq_flag,
    input logic [DW-1:0] err_out
);

    // R6: flag holds without a clear
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R6: flag rises only after a test whose condition held
    assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(st_eval && hit));

    // R6: clear without a concurrent set empties the flag
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(st_eval && hit)) |=> !irq_flag);

    // R4 / R9: error changes only after a completion strobe while go is high
    assert_err_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_out) |-> $past(done && go && !st_eval));

    // R2: go rises only after a start request
    assert_go_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> $past(sw_start || trig_edge));

    // R8: continuous run keeps go unless stop condition met
    assert_cont_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_eval && cont && !(hit && stop_on_irq)) |=> go);

    // R7: single mode drops go after the test
    assert_single_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_eval && !cont) |=> !go);

endmodule

bind cmp_retrig cmp_retrig_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .done        (done),
    .sw_start    (sw_start),
    .trig_edge   (trig_edge),
    .st_eval     (st_eval),
    .hit         (hit),
    .cont        (cfg_cont),
    .stop_on_irq (cfg_stop_on_irq),
    .irq_clr     (irq_clr),
    .irq_flag    (irq_flag),
    .err_out     (err_out)
);

// File: tb/cmp_retrig_tb.sv
module cmp_retrig_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_calc_sel = '0;
    logic [2:0]  cfg_irq_mode = '0;
    logic        cfg_cont = 1'b0;
    logic        cfg_stop_on_irq = 1'b0;
    logic [1:0]  cfg_trig_sel = '0;
    logic [3:0]  trig_in = '0;
    logic        sw_start = 1'b0;
    logic [15:0] result = '0;
    logic [15:0] filtered = '0;
    logic [15:0] setpoint = '0;
    logic [15:0] upper_th = '0;
    logic [15:0] lower_th = '0;
    logic        done = 1'b0;
    logic        irq_clr = 1'b0;
    logic        go;
    logic [15:0] err_out;
    logic        irq_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [15:0] prev_res = '0;

    always #2 clk = ~clk;

    cmp_retrig u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_calc_sel(cfg_calc_sel), .cfg_irq_mode(cfg_irq_mode),
        .cfg_cont(cfg_cont), .cfg_stop_on_irq(cfg_stop_on_irq),
        .cfg_trig_sel(cfg_trig_sel), .trig_in(trig_in), .sw_start(sw_start),
        .result(result), .filtered(filtered), .setpoint(setpoint),
        .upper_th(upper_th), .lower_th(lower_th), .done(done), .irq_clr(irq_clr),
        .go(go), .err_out(err_out), .irq_flag(irq_flag)
    );

    typedef struct packed {
        logic [1:0]  calc;
        logic [2:0]  mode;
        logic [15:0] res;
        logic [15:0] filt;
        logic [15:0] sp;
        logic [15:0] uth;
        logic [15:0] lth;
        logic        irq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 3'd1, 16'd100,  16'd0,   16'd50, 16'd0,   16'd60,     1'b1},
        '{2'd1, 3'd1, 16'd100,  16'd0,   16'd20, 16'd0,   16'd60,     1'b0},
        '{2'd0, 3'd2, 16'd30,   16'd0,   16'd0,  16'd0,   16'hFFBA,   1'b1},
        '{2'd0, 3'd2, 16'd40,   16'd0,   16'd0,  16'd0,   16'd11,     1'b0},
        '{2'd2, 3'd3, 16'd0,    16'd500, 16'd400,16'd200, 16'd100,    1'b1},
        '{2'd2, 3'd3, 16'd0,    16'd600, 16'd400,16'd200, 16'd100,    1'b0},
        '{2'd3, 3'd4, 16'hFFFB, 16'd0,   16'd0,  16'd10,  16'hFFFC,   1'b1},
        '{2'd1, 3'd4, 16'd3,    16'd0,   16'd0,  16'd10,  16'hFFFC,   1'b0},
        '{2'd1, 3'd5, 16'd9,    16'd0,   16'd0,  16'd10,  16'd0,      1'b1},
        '{2'd1, 3'd6, 16'd10,   16'd0,   16'd0,  16'd10,  16'd0,      1'b1},
        '{2'd1, 3'd6, 16'd9,    16'd0,   16'd0,  16'd10,  16'd0,      1'b0},
        '{2'd1, 3'd0, 16'd9,    16'd0,   16'd0,  16'd10,  16'd0,      1'b0},
        '{2'd1, 3'd7, 16'd9,    16'd0,   16'd0,  16'd10,  16'd0,      1'b1},
        '{2'd1, 3'd1, 16'h8000, 16'd0,   16'd1,  16'd10,  16'd0,      1'b0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_err(input logic [1:0] c, input logic [15:0] r,
                                              input logic [15:0] f, input logic [15:0] s,
                                              input logic [15:0] p);
        if (c == 2'd0)      return r - p;
        else if (c == 2'd2) return f - s;
        else                return r - s;
    endfunction

    task automatic pulse_start();
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic pulse_done(input logic [15:0] r);
        result = r;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        prev_res = r;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_e;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(go == 1'b0, "R1 go", int'(go), 0);
        check(err_out == 16'd0, "R1 err", int'(err_out), 0);
        check(irq_flag == 1'b0, "R1 irq", int'(irq_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R4 error, R5 condition, R6 flag, R7 single stop
        for (int i = 0; i < NV; i++) begin
            cfg_calc_sel = VEC[i].calc;
            cfg_irq_mode = VEC[i].mode;
            filtered = VEC[i].filt;
            setpoint = VEC[i].sp;
            upper_th = VEC[i].uth;
            lower_th = VEC[i].lth;
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            pulse_start();
            check(go == 1'b1, "R2 go after sw_start", int'(go), 1);
            exp_e = model_err(VEC[i].calc, VEC[i].res, VEC[i].filt, VEC[i].sp, prev_res);
            pulse_done(VEC[i].res);
            check(err_out == exp_e, $sformatf("R4 err vec %0d", i), int'(err_out), int'(exp_e));
            @(negedge clk);
            check(irq_flag == VEC[i].irq, $sformatf("R5 irq vec %0d", i), int'(irq_flag), int'(VEC[i].irq));
            check(go == 1'b0, $sformatf("R7 go low vec %0d", i), int'(go), 0);
        end

        // R6 sticky, then clear, then set-wins-over-clear
        cfg_calc_sel = 2'd1; setpoint = 16'd0; cfg_irq_mode = 3'd7;
        pulse_start(); pulse_done(16'd5); @(negedge clk);
        cfg_irq_mode = 3'd0;
        pulse_start(); pulse_done(16'd6); @(negedge clk);
        check(irq_flag == 1'b1, "R6 sticky", int'(irq_flag), 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check(irq_flag == 1'b0, "R6 clear", int'(irq_flag), 0);
        cfg_irq_mode = 3'd7;
        pulse_start(); pulse_done(16'd7);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check(irq_flag == 1'b1, "R6 set wins", int'(irq_flag), 1);

        // R9 done while idle is ignored
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        held = err_out;
        pulse_done(16'd999); @(negedge clk);
        prev_res = 16'd7;
        check(err_out == held, "R9 err kept", int'(err_out), int'(held));
        check(irq_flag == 1'b0, "R9 irq kept", int'(irq_flag), 0);

        // R2 trigger path
        cfg_irq_mode = 3'd0;
        cfg_trig_sel = 2'd2;
        trig_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        check(go == 1'b0, "R2 unselected trigger", int'(go), 0);
        trig_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        check(go == 1'b0, "R2 go before third edge", int'(go), 0);
        @(negedge clk);
        check(go == 1'b1, "R2 go on third edge", int'(go), 1);

        // R3 edge while busy dropped
        trig_in[2] = 1'b0;
        repeat (4) @(negedge clk);
        trig_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        pulse_done(16'd1); @(negedge clk);
        check(go == 1'b0, "R3 go falls", int'(go), 0);
        repeat (5) @(negedge clk);
        check(go == 1'b0, "R3 no retrigger", int'(go), 0);
        trig_in = '0;
        repeat (4) @(negedge clk);

        // R8 continuous mode
        cfg_cont = 1'b1; cfg_stop_on_irq = 1'b1; cfg_irq_mode = 3'd0;
        pulse_start(); pulse_done(16'd2); @(negedge clk);
        check(go == 1'b1, "R8 continues", int'(go), 1);
        cfg_irq_mode = 3'd7;
        pulse_done(16'd3); @(negedge clk);
        check(go == 1'b0, "R8 stop on irq", int'(go), 0);
        check(irq_flag == 1'b1, "R8 irq on stop", int'(irq_flag), 1);
        cfg_stop_on_irq = 1'b0;
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        pulse_start(); pulse_done(16'd4); @(negedge clk);
        check(go == 1'b1, "R8 no stop without enable", int'(go), 1);
        check(irq_flag == 1'b1, "R8 irq while running", int'(irq_flag), 1);
        cfg_cont = 1'b0;
        pulse_done(16'd5); @(negedge clk);
        check(go == 1'b0, "R7 leave continuous", int'(go), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule